// File: doc/BRIEF.md
# Link Sequence Numbering and Replay Controller

This block sits between a transaction layer and a physical coding layer of a packetized serial link and makes the link reliable. On the transmit side every fresh packet gets the next 12-bit sequence number, presented beside each of its words. Each packet is also copied into a replay store indexed by the low bits of that number. Cumulative acknowledgements from the far end retire stored packets. A negative acknowledge, or silence for a programmable number of cycles, makes the controller resend every packet still held, oldest first. Fresh traffic is held back during a replay and while the store is full.

On the receive side the block compares the sequence number carried by each arriving packet with the number it expects next. The packet's CRC verdict comes from outside. A packet with the expected number has its words passed upward, and the ok flag on its last word is the CRC verdict. Packets that are behind (duplicates) or ahead are not passed on. One cycle after the last word of every packet, an ACK or NAK indication carries the sequence number to report back to the far end.

Payloads move as word streams with valid/ready handshakes on the transmit side. The receive side takes one word per valid cycle and cannot be stalled.

Top module: `seqrep_link`

## Requirements
- R1: After reset the first fresh packet carries sequence number 0. Each later fresh packet carries the previous number plus one, modulo 4096, so 4095 is followed by 0. `ln_seq` stays constant over all words of a packet.
- R2: Fresh words pass from the `up_*` stream to the `ln_*` stream unchanged and in order. `ln_valid` with `ln_ready` low holds `ln_data`, `ln_last` and `ln_seq` stable until accepted.
- R3: A feedback with `fb_nak`=0 and number N retires every stored packet up to and including N. Feedback whose N lies outside the span from the newest retired number to the newest sent number is ignored.
- R4: A feedback with `fb_nak`=1 and number N first retires packets up to N. It then resends all remaining stored packets, oldest first, with their original words and numbers.
- R5: At most SLOTS packets are unacknowledged. While SLOTS are outstanding, `up_ready` and the fresh `ln_valid` stay low.
- R6: No fresh packet starts while a replay is pending or running. A fresh packet already started completes before the replay begins.
- R7: If packets are outstanding and no feedback arrives for `cfg_timeout` consecutive cycles, every outstanding packet is resent from the oldest.
- R8: A receive packet whose first-word `rx_seq` equals the expected number has every word forwarded on `dn_*`, with `dn_ok` equal to `rx_crc_ok` on the last word. If that verdict is 1, the expected number advances and an indication with `ind_nak`=0 and `ind_seq` = that packet's number follows one cycle after the last word.
- R9: A packet with `rx_crc_ok`=0 on its last word yields `ind_nak`=1 with the last good number, and the expected number does not move.
- R10: A packet whose number is 1 to 2047 ahead of the expected one is not forwarded (`dn_valid` low) and yields `ind_nak`=1 with the last good number.
- R11: A packet whose number is 1 to 2048 behind the expected one (a duplicate) is not forwarded and yields `ind_nak`=0 with the last good number.
- R12: After reset the expected receive number is 0, so the last good number reported is 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_timeout | input | TMR_W | Cycles of feedback silence before a timed replay (non-zero) |
| up_valid | input | 1 | Fresh word from transaction layer valid |
| up_ready | output | 1 | Fresh word accepted |
| up_data | input | 32 | Fresh word data |
| up_last | input | 1 | Fresh word ends its packet |
| ln_valid | output | 1 | Outgoing word valid |
| ln_ready | input | 1 | Outgoing word taken by the physical layer |
| ln_data | output | 32 | Outgoing word data |
| ln_last | output | 1 | Outgoing word ends its packet |
| ln_seq | output | 12 | Sequence number of the outgoing packet |
| fb_valid | input | 1 | Far-end acknowledge feedback valid (one cycle) |
| fb_nak | input | 1 | 1 = negative acknowledge, 0 = acknowledge |
| fb_seq | input | 12 | Sequence number carried by the feedback |
| rx_valid | input | 1 | Received word valid |
| rx_data | input | 32 | Received word data |
| rx_last | input | 1 | Received word ends its packet |
| rx_seq | input | 12 | Packet sequence number, read on the first word |
| rx_crc_ok | input | 1 | CRC verdict, read on the last word |
| dn_valid | output | 1 | Forwarded word valid |
| dn_data | output | 32 | Forwarded word data |
| dn_last | output | 1 | Forwarded word ends its packet |
| dn_ok | output | 1 | On the last word: packet is good |
| ind_valid | output | 1 | ACK/NAK indication valid (one cycle) |
| ind_nak | output | 1 | 1 = NAK, 0 = ACK |
| ind_seq | output | 12 | Sequence number to report |

## Verification
The transmit side is tried with multi-word and single-word packets under output back-pressure. It is also tried with an acknowledge that retires part of the window, then a NAK, which shows cumulative retirement apart from per-packet retirement. A filled window shows the stall. An out-of-window acknowledge followed by a NAK shows that ignored feedback retires nothing. A NAK arriving mid-packet separates holding fresh traffic from cutting a packet short, and a silent far end shows the timer path. The receive side gets in-order, corrupted, ahead, behind and reset-boundary numbers, which set forwarding apart from ACK and NAK reporting. A run of more than 4096 packets covers number wrap.

// File: rtl/seqrep_pkg.sv
package seqrep_pkg;

    localparam int SEQ_W  = 12;
    localparam int DATA_W = 32;
    localparam int HALF   = 1 << (SEQ_W - 1);

    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        logic              last;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef enum logic [1:0] {
        CL_GOOD  = 2'd0,
        CL_DUP   = 2'd1,
        CL_AHEAD = 2'd2
    } rx_class_e;

    // forward modular distance from b to a
    function automatic seq_t seq_dist(seq_t a, seq_t b);
        return a - b;
    endfunction

    function automatic rx_class_e classify(seq_t got, seq_t expect_seq);
        seq_t d;
        d = seq_dist(got, expect_seq);
        if (d == '0)
            return CL_GOOD;
        else if (d >= seq_t'(HALF))
            return CL_DUP;
        else
            return CL_AHEAD;
    endfunction

endpackage

// File: rtl/seqrep_store.sv
module seqrep_store
    import seqrep_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int WORDS = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(SLOTS)-1:0] w_slot,
    input  logic [$clog2(WORDS)-1:0] w_word,
    input  word_t                    w_data,
    input  logic [$clog2(SLOTS)-1:0] r_slot,
    input  logic [$clog2(WORDS)-1:0] r_word,
    output word_t                    r_data
);
    localparam int ENTRIES = SLOTS * WORDS;

    word_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we)
            mem[{w_slot, w_word}] <= w_data;
    end

    assign r_data = mem[{r_slot, r_word}];

endmodule

// File: rtl/seqrep_tx.sv
module seqrep_tx
    import seqrep_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int WORDS = 4,
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TMR_W-1:0]  cfg_timeout,
    input  logic              up_valid,
    output logic              up_ready,
    input  word_t             up_word,
    output logic              ln_valid,
    input  logic              ln_ready,
    output word_t             ln_word,
    output seq_t              ln_seq,
    input  logic              fb_valid,
    input  logic              fb_nak,
    input  seq_t              fb_seq,
    output seq_t              outstanding,
    output logic              replaying
);
    localparam int SL_W = $clog2(SLOTS);
    localparam int WD_W = $clog2(WORDS);

    seq_t             next_seq, head_seq, rp_seq, acked;
    logic             in_pkt, stall_q, pend, full, allow_new;
    logic             fresh_fire, fb_ok, start_rp;
    logic [WD_W-1:0]  wptr, rp_ptr;
    logic [TMR_W-1:0] tmr;
    word_t            rd_word;

    assign outstanding = seq_dist(next_seq, head_seq);
    assign acked       = head_seq - seq_t'(1);
    assign full        = (outstanding == seq_t'(SLOTS));
    assign fb_ok       = fb_valid && (seq_dist(fb_seq, acked) <= outstanding);
    assign allow_new   = in_pkt || stall_q || !(pend || replaying || full);
    assign up_ready    = ln_ready && allow_new && !replaying;
    assign fresh_fire  = up_valid && up_ready;
    assign start_rp    = pend && !replaying && !in_pkt && !stall_q;

    assign ln_valid = replaying || (up_valid && allow_new);
    assign ln_word  = replaying ? rd_word : up_word;
    assign ln_seq   = replaying ? rp_seq  : next_seq;

    seqrep_store #(.SLOTS(SLOTS), .WORDS(WORDS)) u_store (
        .clk    (clk),
        .we     (fresh_fire),
        .w_slot (next_seq[SL_W-1:0]),
        .w_word (wptr),
        .w_data (up_word),
        .r_slot (rp_seq[SL_W-1:0]),
        .r_word (rp_ptr),
        .r_data (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_seq  <= '0;
            head_seq  <= '0;
            rp_seq    <= '0;
            in_pkt    <= 1'b0;
            stall_q   <= 1'b0;
            pend      <= 1'b0;
            replaying <= 1'b0;
            wptr      <= '0;
            rp_ptr    <= '0;
            tmr       <= '0;
        end else begin
            stall_q <= ln_valid && !ln_ready && !replaying;

            if (fresh_fire) begin
                if (up_word.last) begin
                    next_seq <= next_seq + seq_t'(1);
                    in_pkt   <= 1'b0;
                    wptr     <= '0;
                end else begin
                    in_pkt <= 1'b1;
                    wptr   <= wptr + 1'b1;
                end
            end

            if (start_rp) begin
                pend <= 1'b0;
                if (outstanding != '0) begin
                    replaying <= 1'b1;
                    rp_seq    <= head_seq;
                    rp_ptr    <= '0;
                end
            end else if (replaying && ln_ready) begin
                if (rd_word.last) begin
                    rp_ptr <= '0;
                    rp_seq <= rp_seq + seq_t'(1);
                    if (rp_seq + seq_t'(1) == next_seq)
                        replaying <= 1'b0;
                end else begin
                    rp_ptr <= rp_ptr + 1'b1;
                end
            end

            if (fb_valid || outstanding == '0 || replaying || pend) begin
                tmr <= '0;
            end else if (tmr + 1'b1 == cfg_timeout) begin
                tmr  <= '0;
                pend <= 1'b1;
            end else begin
                tmr <= tmr + 1'b1;
            end

            if (fb_ok) begin
                head_seq <= fb_seq + seq_t'(1);
                if (fb_nak)
                    pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/seqrep_rx.sv
module seqrep_rx
    import seqrep_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rx_valid,
    input  word_t rx_word,
    input  seq_t  rx_seq,
    input  logic  rx_crc_ok,
    output logic  dn_valid,
    output word_t dn_word,
    output logic  dn_ok,
    output logic  ind_valid,
    output logic  ind_nak,
    output seq_t  ind_seq
);
    seq_t      exp_seq;
    logic      in_pkt;
    rx_class_e cls, cls_q;

    assign cls      = in_pkt ? cls_q : classify(rx_seq, exp_seq);
    assign dn_valid = rx_valid && (cls == CL_GOOD);
    assign dn_word  = rx_word;
    assign dn_ok    = rx_crc_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_seq   <= '0;
            in_pkt    <= 1'b0;
            cls_q     <= CL_GOOD;
            ind_valid <= 1'b0;
            ind_nak   <= 1'b0;
            ind_seq   <= '0;
        end else begin
            ind_valid <= 1'b0;
            if (rx_valid) begin
                if (rx_word.last) begin
                    in_pkt    <= 1'b0;
                    ind_valid <= 1'b1;
                    if (rx_crc_ok && cls == CL_GOOD) begin
                        exp_seq <= exp_seq + seq_t'(1);
                        ind_nak <= 1'b0;
                        ind_seq <= exp_seq;
                    end else begin
                        ind_nak <= !rx_crc_ok || (cls == CL_AHEAD);
                        ind_seq <= exp_seq - seq_t'(1);
                    end
                end else begin
                    in_pkt <= 1'b1;
                    cls_q  <= cls;
                end
            end
        end
    end

endmodule

// File: rtl/seqrep_link.sv
module seqrep_link
    import seqrep_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int WORDS = 4,
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TMR_W-1:0]  cfg_timeout,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_last,
    output logic              ln_valid,
    input  logic              ln_ready,
    output logic [DATA_W-1:0] ln_data,
    output logic              ln_last,
    output logic [SEQ_W-1:0]  ln_seq,
    input  logic              fb_valid,
    input  logic              fb_nak,
    input  logic [SEQ_W-1:0]  fb_seq,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_last,
    input  logic [SEQ_W-1:0]  rx_seq,
    input  logic              rx_crc_ok,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_last,
    output logic              dn_ok,
    output logic              ind_valid,
    output logic              ind_nak,
    output logic [SEQ_W-1:0]  ind_seq
);
    word_t up_word, ln_word, rx_word, dn_word;
    seq_t  tx_outstanding;
    logic  tx_replaying;

    assign up_word = '{last: up_last, data: up_data};
    assign rx_word = '{last: rx_last, data: rx_data};
    assign ln_data = ln_word.data;
    assign ln_last = ln_word.last;
    assign dn_data = dn_word.data;
    assign dn_last = dn_word.last;

    seqrep_tx #(.SLOTS(SLOTS), .WORDS(WORDS), .TMR_W(TMR_W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .cfg_timeout (cfg_timeout),
        .up_valid    (up_valid),
        .up_ready    (up_ready),
        .up_word     (up_word),
        .ln_valid    (ln_valid),
        .ln_ready    (ln_ready),
        .ln_word     (ln_word),
        .ln_seq      (ln_seq),
        .fb_valid    (fb_valid),
        .fb_nak      (fb_nak),
        .fb_seq      (fb_seq),
        .outstanding (tx_outstanding),
        .replaying   (tx_replaying)
    );

    seqrep_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .rx_seq    (rx_seq),
        .rx_crc_ok (rx_crc_ok),
        .dn_valid  (dn_valid),
        .dn_word   (dn_word),
        .dn_ok     (dn_ok),
        .ind_valid (ind_valid),
        .ind_nak   (ind_nak),
        .ind_seq   (ind_seq)
    );

endmodule

// File: rtl/seqrep_chk.sv
module seqrep_chk
    import seqrep_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              up_ready,
    input logic              ln_valid,
    input logic              ln_ready,
    input logic [DATA_W-1:0] ln_data,
    input logic              ln_last,
    input logic [SEQ_W-1:0]  ln_seq,
    input logic              rx_valid,
    input logic              rx_last,
    input logic              ind_valid,
    input seq_t              tx_outstanding,
    input logic              tx_replaying
);
    // R5: window never exceeds the store
    a_r5_window_cap: assert property (@(posedge clk) disable iff (rst)
        tx_outstanding <= seq_t'(SLOTS));

    // R5: a full store stalls the upper layer
    a_r5_full_stalls: assert property (@(posedge clk) disable iff (rst)
        (tx_outstanding == seq_t'(SLOTS)) |-> !up_ready);

    // R6: no fresh word is taken during a replay
    a_r6_replay_blocks: assert property (@(posedge clk) disable iff (rst)
        tx_replaying |-> !up_ready);

    // R2: outgoing word held while stalled
    a_r2_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (ln_valid && !ln_ready) |=> (ln_valid && $stable(ln_data)
                                      && $stable(ln_last) && $stable(ln_seq)));

    // R8: indications only follow the last word of a received packet
    a_r8_ind_after_last: assert property (@(posedge clk) disable iff (rst)
        ind_valid |-> $past(rx_valid && rx_last));

endmodule

bind seqrep_link seqrep_chk #(.SLOTS(SLOTS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .up_ready       (up_ready),
    .ln_valid       (ln_valid),
    .ln_ready       (ln_ready),
    .ln_data        (ln_data),
    .ln_last        (ln_last),
    .ln_seq         (ln_seq),
    .rx_valid       (rx_valid),
    .rx_last        (rx_last),
    .ind_valid      (ind_valid),
    .tx_outstanding (tx_outstanding),
    .tx_replaying   (tx_replaying)
);

// File: tb/sim_seqrep_link.sv
`timescale 1ns/1ps
module sim_seqrep_link;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_timeout = 16'd1000;
    logic        up_valid = 1'b0, up_last = 1'b0, ln_ready = 1'b1;
    logic [31:0] up_data = '0;
    logic        fb_valid = 1'b0, fb_nak = 1'b0;
    logic [11:0] fb_seq = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0, rx_crc_ok = 1'b0;
    logic [31:0] rx_data = '0;
    logic [11:0] rx_seq = '0;
    logic        up_ready, ln_valid, ln_last, dn_valid, dn_last, dn_ok;
    logic        ind_valid, ind_nak;
    logic [31:0] ln_data, dn_data;
    logic [11:0] ln_seq, ind_seq;

    always #2.5 clk = ~clk;

    seqrep_link u0 (.*);

    typedef struct packed {
        logic [31:0] d;
        logic        l;
        logic [11:0] s;
    } item_t;

    item_t exp_q[$];
    int    checks = 0, errors = 0, nseq = 0;
    bit    seen_wrap = 0;
    bit    done = 0;
    logic [11:0] prev_seq = '0;

    function automatic logic [31:0] pat(int seq, int i);
        return 32'hA500_0000 | (32'(seq % 4096) << 8) | 32'(i);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // scoreboard monitor on the outgoing stream
    always @(negedge clk) begin
        if (!rst && ln_valid && ln_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R4", "unexpected outgoing word, seq", int'(ln_seq), -1);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(ln_seq == e.s, "R1", "outgoing seq", int'(ln_seq), int'(e.s));
                chk(ln_data == e.d && ln_last == e.l, "R2", "outgoing data",
                    int'(ln_data), int'(e.d));
                if (ln_seq == 12'd0 && prev_seq == 12'd4095) seen_wrap = 1;
                prev_seq = ln_seq;
            end
        end
    end

    task automatic push_pkt(int seq, int n);
        for (int i = 0; i < n; i++)
            exp_q.push_back('{d: pat(seq, i), l: (i == n - 1), s: 12'(seq % 4096)});
    endtask

    task automatic send_pkt(int n);
        int  seq;
        bit  hs;
        seq = nseq;
        for (int i = 0; i < n; i++) begin
            up_valid = 1'b1;
            up_data  = pat(seq, i);
            up_last  = (i == n - 1);
            do begin
                @(negedge clk);
                hs = up_ready;
                @(posedge clk);
                #1;
            end while (!hs);
        end
        up_valid = 1'b0;
        up_last  = 1'b0;
        nseq++;
    endtask

    task automatic send_fb(bit nak, int seq);
        fb_valid = 1'b1;
        fb_nak   = nak;
        fb_seq   = 12'(seq % 4096);
        @(posedge clk);
        #1;
        fb_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rx_pkt(int seq, int n, bit crc, bit fwd, bit nak_e, int iseq, string req);
        for (int i = 0; i < n; i++) begin
            rx_valid  = 1'b1;
            rx_seq    = (i == 0) ? 12'(seq) : 12'hFFF;
            rx_data   = pat(seq, i) ^ 32'h0F0F_0000;
            rx_last   = (i == n - 1);
            rx_crc_ok = (i == n - 1) ? crc : 1'b0;
            @(negedge clk);
            chk(dn_valid == fwd, req, "forward flag", int'(dn_valid), int'(fwd));
            if (fwd) begin
                chk(dn_data == rx_data && dn_last == rx_last, req, "forward data",
                    int'(dn_data), int'(rx_data));
                if (i == n - 1)
                    chk(dn_ok == crc, req, "forward ok", int'(dn_ok), int'(crc));
            end
            @(posedge clk);
            #1;
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        @(negedge clk);
        chk(ind_valid == 1'b1, req, "indication valid", int'(ind_valid), 1);
        chk(ind_nak == nak_e, req, "indication nak", int'(ind_nak), int'(nak_e));
        chk(ind_seq == 12'(iseq), req, "indication seq", int'(ind_seq), iseq);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        #1;
        @(negedge clk);
        chk(ln_valid == 0, "R1", "reset ln_valid", int'(ln_valid), 0);
        chk(up_ready == 1, "R5", "reset up_ready", int'(up_ready), 1);
        chk(ind_valid == 0 && dn_valid == 0, "R12", "reset rx outputs", int'(ind_valid), 0);
        @(posedge clk);
        #1;

        // ---- receive side ----
        rx_pkt(4095, 1, 1, 0, 0, 4095, "R12");  // behind expected 0: duplicate
        rx_pkt(0, 3, 1, 1, 0, 0, "R8");
        rx_pkt(1, 2, 0, 1, 1, 0, "R9");          // bad CRC
        rx_pkt(1, 2, 1, 1, 0, 1, "R8");
        rx_pkt(5, 2, 1, 0, 1, 1, "R10");         // ahead
        rx_pkt(0, 2, 1, 0, 0, 1, "R11");         // duplicate
        rx_pkt(2, 1, 1, 1, 0, 2, "R8");

        // ---- transmit: basic, stall, cumulative ack then nak ----
        push_pkt(0, 3);
        fork
            send_pkt(3);
            begin
                ln_ready = 1'b0;
                @(negedge clk);
                chk(ln_valid == 1, "R2", "valid held while stalled", int'(ln_valid), 1);
                idle(3);
                ln_ready = 1'b1;
            end
        join
        push_pkt(1, 1); send_pkt(1);
        push_pkt(2, 2); send_pkt(2);
        idle(2);
        send_fb(0, 1);                 // retire 0 and 1
        push_pkt(2, 2);                // only packet 2 is replayed
        send_fb(1, 1);
        idle(6);
        chk(exp_q.size() == 0, "R4", "nak replay done", exp_q.size(), 0);
        send_fb(0, 2);

        // ---- fill the window ----
        for (int k = 0; k < 4; k++) begin
            push_pkt(nseq, 1);
            send_pkt(1);
        end
        fork
            send_pkt(2);               // packet 7, held off
            begin
                repeat (3) begin
                    @(negedge clk);
                    chk(up_ready == 0 && ln_valid == 0, "R5", "stall when full",
                        int'(up_ready), 0);
                end
                @(posedge clk);
                #1;
                push_pkt(7, 2);
                send_fb(0, 4);
            end
        join
        idle(2);
        chk(exp_q.size() == 0, "R5", "held packet sent after ack", exp_q.size(), 0);
        send_fb(0, 7);

        // ---- out-of-window ack ignored ----
        push_pkt(8, 1); send_pkt(1);
        idle(2);
        send_fb(0, 20);
        push_pkt(8, 1);
        send_fb(1, 7);
        idle(5);
        chk(exp_q.size() == 0, "R3", "ignored ack kept packet 8", exp_q.size(), 0);
        send_fb(0, 8);

        // ---- fresh traffic held during replay ----
        push_pkt(9, 2); send_pkt(2);
        push_pkt(10, 1); send_pkt(1);
        idle(2);
        push_pkt(9, 2);
        push_pkt(10, 1);
        send_fb(1, 8);
        @(negedge clk);
        chk(up_ready == 0, "R6", "up_ready low with replay pending", int'(up_ready), 0);
        @(posedge clk);
        #1;
        push_pkt(11, 1);
        send_pkt(1);
        idle(2);
        chk(exp_q.size() == 0, "R6", "replay before fresh", exp_q.size(), 0);

        // ---- nak during a fresh packet: packet completes first ----
        push_pkt(12, 3);
        push_pkt(12, 3);
        fork
            send_pkt(3);
            begin
                @(posedge clk);
                #1;
                send_fb(1, 11);
            end
        join
        idle(8);
        chk(exp_q.size() == 0, "R6", "started packet completed then replayed",
            exp_q.size(), 0);
        send_fb(0, 12);

        // ---- replay timer ----
        cfg_timeout = 16'd30;
        push_pkt(13, 1); send_pkt(1);
        push_pkt(13, 1);
        idle(10);
        chk(exp_q.size() == 1, "R7", "no early timed replay", exp_q.size(), 1);
        idle(35);
        chk(exp_q.size() == 0, "R7", "timed replay", exp_q.size(), 0);
        send_fb(0, 13);
        cfg_timeout = 16'd1000;

        // ---- sequence wrap ----
        for (int k = 0; k < 4084; k++) begin
            push_pkt(nseq, 1);
            send_pkt(1);
            send_fb(0, nseq - 1);
        end
        idle(3);
        chk(seen_wrap == 1, "R1", "seq 4095 followed by 0", int'(seen_wrap), 1);
        chk(exp_q.size() == 0, "R1", "all wrap packets seen", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule